// File: doc/BRIEF.md
# Inter-processor message mailbox with per-user interrupts

This block lets several processors pass 32-bit words to each other through a set of small hardware queues. Every queue is reached through one word of a byte-addressed register bus. A bus write to that word appends a message, and a bus read removes the oldest one. Each queue also exposes a full indication and an occupancy count, so software can poll instead of waiting for an interrupt.

Every processor, called a user here, owns an interrupt status word and an interrupt enable word. Each queue drives two events into every user's status word. The first event fires whenever a message is accepted. The second fires whenever a read frees the first slot of a full queue. The receiver of a queue can therefore enable only its arrival event, and the sender can enable only its space event, on the same queue. A user's interrupt pin is high when any enabled status bit is set.

The register bus has no back-pressure. Every access completes in the cycle its strobe is sampled, and read data is valid on the following cycle. A configuration word holds idle-policy bits and a self-clearing soft-reset request. A status word reports when that soft reset has finished, and a read-only word gives the revision.

Top module: `mbx_hub`

## Requirements
- R1: Words read from a queue's message word (byte address 0x040 + 4m) come out in the order they were written, and a queue holds up to DEPTH (default 4) words.
- R2: A write to a queue that already holds DEPTH words is dropped and its data is lost. The full word (0x080 + 4m) reads 1 when the queue holds DEPTH words and 0 otherwise.
- R3: The count word (0x0C0 + 4m) reads the number of stored words. A read of an empty queue's message word returns 0 and leaves the count at 0.
- R4: Every accepted write to queue m sets bit 2m of the status word (0x100 + 8u) of every user u.
- R5: A read that takes queue m from full to not full sets bit 2m+1 of every user's status word.
- R6: Writing the status word clears each bit written as 1 and leaves each bit written as 0 unchanged. The enable word (0x104 + 8u) reads back the last value written, restricted to the 2*NUM_MBOX event bits.
- R7: Output irq_o[u] is active high. In each cycle it equals the OR over all bits of (status AND enable) of user u as they stood in the previous cycle.
- R8: Writing the configuration word (0x010) with bit 1 set clears all queues, all status and enable words, and the configuration bits. Bit 0 of the status word (0x014) then reads 0 for SRST_CYC cycles and reads 1 afterwards and after power-on reset. Bit 1 of the configuration word always reads 0.
- R9: The revision word (0x000) reads REV_MAJOR in bits 7:4 and REV_MINOR in bits 3:0. The configuration word stores an autoidle bit at bit 0 and a two-bit idle mode in bits 4:3, and all its other bits read 0.
- R10: Read data appears on bus_rdata one cycle after a read strobe. While a soft reset is in progress, all bus writes are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_addr | input | AW | Byte address of the access |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe; ignored when bus_wr is also high |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Read data, registered |
| irq_o | output | NUM_USER | Interrupt per user, active high |

## Verification
The case hardest to reach from the ports is the space event. It needs a queue filled to exactly DEPTH words and then read, and random traffic rarely lines that up. It also needs a user that has enabled that bit, so the effect shows on irq_o. The stimulus weights writes above reads, so that queues often sit at the full boundary, and a directed sequence fills a queue past full before draining it. The soft-reset window is reached by issuing a message write and a status read in the very cycles after the reset request.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  localparam logic [11:0] OFS_REV = 12'h000;
  localparam logic [11:0] OFS_CFG = 12'h010;
  localparam logic [11:0] OFS_STS = 12'h014;
  localparam int CFG_AUTO_BIT = 0;
  localparam int CFG_SRST_BIT = 1;
  localparam int CFG_IDLE_LSB = 3;
  localparam logic [5:0] WIN_MSG  = 6'd1;
  localparam logic [5:0] WIN_FULL = 6'd2;
  localparam logic [5:0] WIN_CNT  = 6'd3;
  localparam logic [3:0] WIN_IRQ  = 4'd1;
endpackage

// File: rtl/mbx_fifo.sv
module mbx_fifo #(
  parameter int DW    = 32,
  parameter int DEPTH = 4,
  localparam int CW   = $clog2(DEPTH + 1),
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          push,
  input  logic [DW-1:0] wdata,
  input  logic          pop,
  output logic [DW-1:0] head,
  output logic [CW-1:0] count,
  output logic          full,
  output logic          push_ev,
  output logic          nf_ev
);
  logic [DW-1:0] mem [DEPTH];
  logic [PW-1:0] wp, rp;
  logic          empty, push_ok, pop_ok;

  function automatic logic [PW-1:0] step(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full    = (count == CW'(DEPTH));
  assign empty   = (count == '0);
  assign push_ok = push && !full;
  assign pop_ok  = pop && !empty;
  assign push_ev = push_ok;
  assign nf_ev   = pop_ok && full;
  assign head    = empty ? '0 : mem[rp];

  always_ff @(posedge clk) begin
    if (push_ok) mem[wp] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else begin
      if (push_ok) wp <= step(wp);
      if (pop_ok)  rp <= step(rp);
      case ({push_ok, pop_ok})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  p_no_overflow_r2: assert property (@(posedge clk) disable iff (rst)
    count <= CW'(DEPTH));
  p_full_drop_r2: assert property (@(posedge clk) disable iff (rst)
    (full && push && !pop && !clr) |=> (count == $past(count)));
  p_empty_read_r3: assert property (@(posedge clk) disable iff (rst)
    (empty && pop && !push && !clr) |=> (count == '0));
endmodule

// File: rtl/mbx_irq.sv
module mbx_irq #(
  parameter int EW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic [EW-1:0] set_vec,
  input  logic          clr_we,
  input  logic [EW-1:0] wmask,
  input  logic          en_we,
  input  logic [EW-1:0] en_wdata,
  output logic [EW-1:0] status,
  output logic [EW-1:0] enable,
  output logic          irq
);
  logic [EW-1:0] drop;

  assign drop = clr_we ? wmask : '0;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      status <= '0;
      enable <= '0;
      irq    <= 1'b0;
    end else begin
      status <= (status & ~drop) | set_vec;
      if (en_we) enable <= en_wdata;
      irq <= |(status & enable);
    end
  end

  p_set_r4: assert property (@(posedge clk) disable iff (rst)
    ((|set_vec) && !clr) |=> ((status & $past(set_vec)) == $past(set_vec)));
  p_w1c_r6: assert property (@(posedge clk) disable iff (rst)
    (clr_we && !clr) |=> ((status & $past(wmask) & ~$past(set_vec)) == '0));
  p_irq_r7: assert property (@(posedge clk) disable iff (rst)
    !clr |=> (irq == $past(|(status & enable))));
endmodule

// File: rtl/mbx_hub.sv
module mbx_hub
  import mbx_pkg::*;
#(
  parameter int NUM_MBOX  = 4,
  parameter int NUM_USER  = 4,
  parameter int DEPTH     = 4,
  parameter int DW        = 32,
  parameter int AW        = 12,
  parameter int SRST_CYC  = 3,
  parameter int REV_MAJOR = 2,
  parameter int REV_MINOR = 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [AW-1:0]       bus_addr,
  input  logic                bus_wr,
  input  logic                bus_rd,
  input  logic [DW-1:0]       bus_wdata,
  output logic [DW-1:0]       bus_rdata,
  output logic [NUM_USER-1:0] irq_o
);
  localparam int EW  = 2 * NUM_MBOX;
  localparam int CW  = $clog2(DEPTH + 1);
  localparam int SCW = $clog2(SRST_CYC + 1);

  logic [SCW-1:0] srst_cnt;
  logic           busy, wr_ok, rd_ok, srst_req, clr;
  logic           cfg_auto;
  logic [1:0]     cfg_idle;
  logic [3:0]     mb_idx;
  logic [4:0]     us_idx;
  logic [5:0]     win6;
  logic           is_cfg;
  logic [EW-1:0]  set_vec;
  logic [DW-1:0]  rmux;

  logic [DW-1:0]  head  [NUM_MBOX];
  logic [CW-1:0]  cnt   [NUM_MBOX];
  logic           full  [NUM_MBOX];
  logic [EW-1:0]  st    [NUM_USER];
  logic [EW-1:0]  en    [NUM_USER];

  assign win6     = bus_addr[11:6];
  assign mb_idx   = bus_addr[5:2];
  assign us_idx   = bus_addr[7:3];
  assign is_cfg   = (bus_addr == OFS_CFG);
  assign busy     = (srst_cnt != '0);
  assign wr_ok    = bus_wr && !busy;
  assign rd_ok    = bus_rd && !bus_wr;
  assign srst_req = wr_ok && is_cfg && bus_wdata[CFG_SRST_BIT];
  assign clr      = srst_req || busy;

  always_ff @(posedge clk) begin
    if (rst) srst_cnt <= '0;
    else if (srst_req) srst_cnt <= SCW'(SRST_CYC);
    else if (busy) srst_cnt <= srst_cnt - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cfg_auto <= 1'b0;
      cfg_idle <= '0;
    end else if (wr_ok && is_cfg) begin
      cfg_auto <= bus_wdata[CFG_AUTO_BIT];
      cfg_idle <= bus_wdata[CFG_IDLE_LSB +: 2];
    end
  end

  for (genvar m = 0; m < NUM_MBOX; m++) begin : g_box
    logic hit;
    assign hit = (win6 == WIN_MSG) && (mb_idx == 4'(m));
    mbx_fifo #(.DW(DW), .DEPTH(DEPTH)) u_fifo (
      .clk     (clk),
      .rst     (rst),
      .clr     (clr),
      .push    (wr_ok && hit),
      .wdata   (bus_wdata),
      .pop     (rd_ok && !busy && hit),
      .head    (head[m]),
      .count   (cnt[m]),
      .full    (full[m]),
      .push_ev (set_vec[2*m]),
      .nf_ev   (set_vec[2*m+1])
    );
  end

  for (genvar u = 0; u < NUM_USER; u++) begin : g_user
    logic hit;
    assign hit = (bus_addr[11:8] == WIN_IRQ) && (us_idx == 5'(u));
    mbx_irq #(.EW(EW)) u_irq (
      .clk      (clk),
      .rst      (rst),
      .clr      (clr),
      .set_vec  (set_vec),
      .clr_we   (wr_ok && hit && !bus_addr[2]),
      .wmask    (bus_wdata[EW-1:0]),
      .en_we    (wr_ok && hit && bus_addr[2]),
      .en_wdata (bus_wdata[EW-1:0]),
      .status   (st[u]),
      .enable   (en[u]),
      .irq      (irq_o[u])
    );
  end

  always_comb begin
    rmux = '0;
    if (bus_addr == OFS_REV)
      rmux = DW'({4'(REV_MAJOR), 4'(REV_MINOR)});
    else if (is_cfg)
      rmux = DW'({cfg_idle, 2'b00, cfg_auto});
    else if (bus_addr == OFS_STS)
      rmux = DW'(!busy);
    for (int k = 0; k < NUM_MBOX; k++) begin
      if (32'(mb_idx) == k) begin
        if (win6 == WIN_MSG)  rmux = head[k];
        if (win6 == WIN_FULL) rmux = DW'(full[k]);
        if (win6 == WIN_CNT)  rmux = DW'(cnt[k]);
      end
    end
    for (int k = 0; k < NUM_USER; k++) begin
      if (bus_addr[11:8] == WIN_IRQ && 32'(us_idx) == k)
        rmux = bus_addr[2] ? DW'(en[k]) : DW'(st[k]);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else if (rd_ok) bus_rdata <= rmux;
  end

  logic any_left;
  always_comb begin
    any_left = 1'b0;
    for (int k = 0; k < NUM_MBOX; k++) any_left = any_left | (cnt[k] != '0);
    for (int k = 0; k < NUM_USER; k++) any_left = any_left | (st[k] != '0) | (en[k] != '0);
  end

  p_srst_clear_r8: assert property (@(posedge clk) disable iff (rst)
    srst_req |=> !any_left);
  p_rev_read_r9: assert property (@(posedge clk) disable iff (rst)
    (rd_ok && bus_addr == OFS_REV) |=> (bus_rdata == DW'({4'(REV_MAJOR), 4'(REV_MINOR)})));
  p_busy_nowrite_r10: assert property (@(posedge clk) disable iff (rst)
    (busy && bus_wr) |=> (cfg_auto == 1'b0 && cfg_idle == 2'b00));
endmodule

// File: tb/mbx_hub_bench.sv
`timescale 1ns/1ps
module mbx_hub_bench;
  localparam int NM = 4;
  localparam int NU = 4;
  localparam int DEPTH = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [11:0] bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [NU-1:0] irq_o;

  always #2.5 clk = ~clk;

  mbx_hub u_mbx_hub (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq_o)
  );

  int checks = 0;
  int failures = 0;
  logic [31:0] mq [NM][$];
  logic [7:0]  st [NU];
  logic [7:0]  en [NU];

  function automatic logic [11:0] a_msg(int m);  return 12'(32'h040 + 4*m); endfunction
  function automatic logic [11:0] a_full(int m); return 12'(32'h080 + 4*m); endfunction
  function automatic logic [11:0] a_cnt(int m);  return 12'(32'h0C0 + 4*m); endfunction
  function automatic logic [11:0] a_st(int u);   return 12'(32'h100 + 8*u); endfunction
  function automatic logic [11:0] a_en(int u);   return 12'(32'h104 + 8*u); endfunction
  function automatic logic exp_irq(int u);       return |(st[u] & en[u]); endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (act !== expv) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [11:0] a, output logic [31:0] d);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic idle();
    @(negedge clk);
  endtask

  task automatic model_clear();
    for (int i = 0; i < NM; i++) mq[i].delete();
    for (int i = 0; i < NU; i++) begin st[i] = '0; en[i] = '0; end
  endtask

  task automatic model_push(int m, logic [31:0] d);
    if (mq[m].size() < DEPTH) begin
      mq[m].push_back(d);
      for (int i = 0; i < NU; i++) st[i][2*m] = 1'b1;
    end
  endtask

  task automatic read_msg_chk(int m);
    logic [31:0] r, e;
    e = '0;
    if (mq[m].size() > 0) begin
      if (mq[m].size() == DEPTH) for (int i = 0; i < NU; i++) st[i][2*m+1] = 1'b1;
      e = mq[m].pop_front();
    end
    bus_read(a_msg(m), r);
    chk(e == 0 ? "R3 empty/zero read" : "R1 order", r, e);
  endtask

  logic [31:0] rv;

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    model_clear();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // reset state
    chk("R7 irq after reset", 32'(irq_o), 32'h0);
    bus_read(12'h000, rv); chk("R9 revision", rv, 32'h21);
    bus_read(12'h014, rv); chk("R8 done after reset", rv, 32'h1);
    bus_read(a_cnt(0), rv); chk("R3 count reset", rv, 0);

    // R9 config fields
    bus_write(12'h010, 32'h19); bus_read(12'h010, rv); chk("R9 cfg store", rv, 32'h19);
    bus_write(12'h010, 32'hFFFF_FFE5); bus_read(12'h010, rv); chk("R9 cfg mask", rv, 32'h01);
    bus_write(12'h010, 32'h0);

    // R2 fill past full on mailbox 0
    for (int i = 0; i < 5; i++) begin
      bus_write(a_msg(0), 32'hA000_0000 + i);
      model_push(0, 32'hA000_0000 + i);
    end
    bus_read(a_cnt(0), rv); chk("R2 count at full", rv, DEPTH);
    bus_read(a_full(0), rv); chk("R2 full flag", rv, 1);
    bus_read(a_st(2), rv); chk("R4 newmsg bit all users", rv, {24'h0, st[2]});
    chk("R4 newmsg model", 32'(st[2]), 32'h01);
    // R5 enable space event on user1, pop once
    bus_write(a_en(1), 32'h02); en[1] = 8'h02;
    idle(); chk("R7 irq not yet", 32'(irq_o[1]), 0);
    read_msg_chk(0);
    bus_read(a_st(1), rv); chk("R5 notfull bit", rv, 32'h03);
    idle(); chk("R7 irq on notfull", 32'(irq_o[1]), 1);
    bus_read(a_full(0), rv); chk("R2 not full", rv, 0);
    // R6 write 0 keeps, write 1 clears
    bus_write(a_st(1), 32'h0); bus_read(a_st(1), rv); chk("R6 zero keeps", rv, 32'h03);
    bus_write(a_st(1), 32'h2); st[1][1] = 1'b0;
    bus_read(a_st(1), rv); chk("R6 w1c", rv, 32'h01);
    idle(); chk("R7 irq cleared", 32'(irq_o[1]), 0);
    bus_write(a_en(1), 32'hFFFF_FFFF); en[1] = 8'hFF;
    bus_read(a_en(1), rv); chk("R6 enable mask", rv, 32'hFF);
    for (int i = 0; i < 4; i++) read_msg_chk(0);
    bus_read(a_cnt(0), rv); chk("R3 count after empty read", rv, 0);

    // random traffic
    for (int it = 0; it < 4000; it++) begin
      int op, m, u;
      logic [31:0] d;
      op = $urandom_range(0, 11); m = $urandom_range(0, NM-1);
      u = $urandom_range(0, NU-1); d = $urandom;
      case (op)
        0, 1, 2, 3: begin bus_write(a_msg(m), d); model_push(m, d); end
        4, 5: read_msg_chk(m);
        6: begin
          bus_read(a_cnt(m), rv); chk("R3 count", rv, mq[m].size());
          bus_read(a_full(m), rv); chk("R2 full", rv, 32'(mq[m].size() == DEPTH));
        end
        7: begin bus_write(a_en(u), d); en[u] = d[7:0]; end
        8: if (d[31:29] == 0) begin bus_write(a_st(u), d); st[u] = st[u] & ~d[7:0]; end
        9: begin
          bus_read(a_st(u), rv); chk("R4 R5 R6 status", rv, {24'h0, st[u]});
          bus_read(a_en(u), rv); chk("R6 enable", rv, {24'h0, en[u]});
        end
        default: begin
          idle();
          for (int k = 0; k < NU; k++) chk("R7 irq", 32'(irq_o[k]), 32'(exp_irq(k)));
        end
      endcase
    end

    // R8 / R10 soft reset
    bus_write(a_en(0), 32'h01); bus_write(a_msg(1), 32'h55);
    bus_write(12'h010, 32'h1B);
    bus_write(a_msg(1), 32'h77);
    bus_write(12'h010, 32'h09);
    bus_read(12'h014, rv); chk("R8 busy reads 0", rv, 0);
    repeat (5) idle();
    model_clear();
    bus_read(12'h014, rv); chk("R8 done", rv, 1);
    bus_read(12'h010, rv); chk("R8 R10 cfg cleared, write ignored", rv, 0);
    bus_read(a_cnt(1), rv); chk("R10 write ignored while busy", rv, 0);
    bus_read(a_en(0), rv); chk("R8 enable cleared", rv, 0);
    bus_read(a_st(0), rv); chk("R8 status cleared", rv, 0);
    chk("R8 irq cleared", 32'(irq_o), 0);
    bus_write(a_msg(1), 32'h99); model_push(1, 32'h99);
    read_msg_chk(1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule